// File: doc/BRIEF.md
# Transmit Jabber Guard

This block sits on the transmit path between a MAC and the line encoder. It watches the transmit-enable signal coming from the MAC. If that signal stays high longer than any legal frame could last, the block treats it as jabber, a stuck or faulty transmitter. It then stops driving the line by forcing the line-side transmit enable low. The abort lasts for as long as the MAC keeps transmit enable high. The guard rearms as soon as transmit enable is released.

The timer counts reference-clock cycles. Its limit is a parameter, so a simulation can use a small value. The default limit is 2,240,000 cycles, which is 44.8 ms at a 50 MHz reference clock.

A sticky status flag records that jabber happened, so a management register can report it. The flag clears on a read strobe, but only when the jabber condition is no longer in force.

Top module: `jabber_guard`

## Requirements
- R1: While reset is high and on the first cycle after reset, `tx_en_line`, `jabber_active` and `jabber_seen` are all 0.
- R2: While fewer than LIMIT consecutive cycles of `tx_en_mac` high have been seen, `tx_en_line` equals the value `tx_en_mac` had at the previous clock edge.
- R3: On the LIMIT-th consecutive clock edge that samples `tx_en_mac` high, `jabber_active` becomes 1 and `tx_en_line` becomes 0.
- R4: Once active, the abort stays in force for every cycle that `tx_en_mac` remains high, however long. The internal count saturates and does not wrap.
- R5: A clock edge that samples `tx_en_mac` low clears `jabber_active`. The next high period counts again from zero.
- R6: A high period of `tx_en_mac` shorter than LIMIT cycles never raises `jabber_active` or `jabber_seen`.
- R7: `jabber_seen` rises on the same edge as `jabber_active`. It stays 1 until an edge that samples `rd_clear` high while `jabber_active` is 0.
- R8: A `rd_clear` sampled while `jabber_active` is 1 does not clear `jabber_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en_mac | input | 1 | Transmit enable from the MAC |
| rd_clear | input | 1 | Status read strobe, one cycle |
| tx_en_line | output | 1 | Gated transmit enable toward the line (registered) |
| jabber_active | output | 1 | Jabber condition currently in force |
| jabber_seen | output | 1 | Sticky jabber status flag |

## Verification
The bench uses a small limit and sweeps the length of the transmit-enable pulse from one cycle up to well past the limit. The pulse lengths just below and just at the limit catch an off-by-one in the compare, which would clip a legal frame or let one extra cycle through. Pulses several times the limit catch a counter that wraps and briefly re-enables the line. Back-to-back pulses separated by a single idle cycle catch a timer that fails to restart from zero. Status reads issued during the abort catch a flag that clears too early, and reads issued after the release catch a flag that never clears.

// File: rtl/jabber_pkg.sv
package jabber_pkg;
  // 44.8 ms at 50 MHz
  localparam int unsigned JAB_LIMIT_DEFAULT = 2_240_000;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/jg_timer.sv
module jg_timer #(
  parameter int unsigned LIMIT = jabber_pkg::JAB_LIMIT_DEFAULT,
  localparam int unsigned CW   = jabber_pkg::cnt_width(LIMIT)
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  output logic hit_next
);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (!tx_en)
      cnt_d = '0;
    else if (cnt_q == LIM)
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + 1'b1;
  end

  assign hit_next = tx_en && (cnt_d == LIM);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/jg_gate.sv
module jg_gate (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic hit_next,
  output logic line_en,
  output logic active
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_en <= 1'b0;
      active  <= 1'b0;
    end else begin
      line_en <= tx_en & ~hit_next;
      active  <= hit_next;
    end
  end
endmodule

// File: rtl/jg_sticky.sv
module jg_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_in,
  input  logic active_now,
  input  logic rd_clear,
  output logic flag
);
  logic clr;
  assign clr = rd_clear & ~active_now;

  always_ff @(posedge clk) begin
    if (rst)         flag <= 1'b0;
    else if (set_in) flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard #(
  parameter int unsigned LIMIT = jabber_pkg::JAB_LIMIT_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en_mac,
  input  logic rd_clear,
  output logic tx_en_line,
  output logic jabber_active,
  output logic jabber_seen
);
  logic hit_next;

  jg_timer #(.LIMIT(LIMIT)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en_mac),
    .hit_next (hit_next)
  );

  jg_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en_mac),
    .hit_next (hit_next),
    .line_en  (tx_en_line),
    .active   (jabber_active)
  );

  jg_sticky u_sticky (
    .clk        (clk),
    .rst        (rst),
    .set_in     (hit_next),
    .active_now (jabber_active),
    .rd_clear   (rd_clear),
    .flag       (jabber_seen)
  );
endmodule

// File: rtl/jabber_guard_chk.sv
module jabber_guard_chk (
  input logic clk,
  input logic rst,
  input logic tx_en_mac,
  input logic rd_clear,
  input logic tx_en_line,
  input logic jabber_active,
  input logic jabber_seen
);
  assert_line_blocked_R3: assert property (@(posedge clk) disable iff (rst)
    jabber_active |-> !tx_en_line);

  assert_line_needs_tx_R2: assert property (@(posedge clk) disable iff (rst)
    tx_en_line |-> $past(tx_en_mac));

  assert_abort_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (jabber_active && tx_en_mac) |=> jabber_active);

  assert_release_clears_R5: assert property (@(posedge clk) disable iff (rst)
    !tx_en_mac |=> !jabber_active);

  assert_flag_with_active_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(jabber_active) |-> jabber_seen);

  assert_no_clear_while_active_R8: assert property (@(posedge clk) disable iff (rst)
    (jabber_active && jabber_seen) |=> jabber_seen);
endmodule

bind jabber_guard jabber_guard_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .tx_en_mac     (tx_en_mac),
  .rd_clear      (rd_clear),
  .tx_en_line    (tx_en_line),
  .jabber_active (jabber_active),
  .jabber_seen   (jabber_seen)
);

// File: tb/jabber_guard_tb.sv
module jabber_guard_tb;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en_mac = 1'b0;
  logic rd_clear = 1'b0;
  logic tx_en_line, jabber_active, jabber_seen;

  int n_run = 0;
  int n_fail = 0;
  int k = 0;
  logic m_line = 0, m_act = 0, m_seen = 0;

  always #2.5 clk = ~clk;

  jabber_guard #(.LIMIT(L)) u_dut (
    .clk(clk), .rst(rst), .tx_en_mac(tx_en_mac), .rd_clear(rd_clear),
    .tx_en_line(tx_en_line), .jabber_active(jabber_active), .jabber_seen(jabber_seen)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b time=%0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle: drive, clock, update the arithmetic model, compare.
  task automatic step(input logic tx, input logic rd, input string req);
    logic prev_act;
    tx_en_mac = tx;
    rd_clear  = rd;
    @(posedge clk);
    prev_act = m_act;
    k = tx ? ((k < L) ? k + 1 : L) : 0;
    m_act  = tx && (k >= L);
    m_line = tx && (k < L);
    m_seen = (tx && k == L) ? 1'b1 : (m_seen && !(rd && !prev_act));
    #1;
    chk(req, tx_en_line,    m_line, "tx_en_line");
    chk(req, jabber_active, m_act,  "jabber_active");
    chk(req, jabber_seen,   m_seen, "jabber_seen");
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1", tx_en_line, 1'b0, "tx_en_line in reset");
    chk("R1", jabber_active, 1'b0, "jabber_active in reset");
    chk("R1", jabber_seen, 1'b0, "jabber_seen in reset");
    rst = 1'b0;
    step(1'b0, 1'b0, "R1");

    // R2 R6: pulses shorter than the limit pass through and never set status
    for (int len = 1; len < L; len++) begin
      for (int c = 0; c < len; c++) step(1'b1, 1'b0, "R2");
      step(1'b0, 1'b0, "R6");
    end
    chk("R6", jabber_seen, 1'b0, "no status after short pulses");

    // R3 R4 R8: pulses at and past the limit; reads issued during abort
    for (int len = L; len <= 3 * L + 2; len += 3) begin
      for (int c = 0; c < len; c++) step(1'b1, (c == len - 1), "R3");
      chk("R8", jabber_seen, 1'b1, "status kept through read while active");
      // R5: release clears active, then R7 read clears status
      step(1'b0, 1'b0, "R5");
      step(1'b0, 1'b1, "R7");
      chk("R7", jabber_seen, 1'b0, "status cleared by read after release");
    end

    // R5: back-to-back long pulses with one idle cycle; count restarts
    for (int c = 0; c < L + 2; c++) step(1'b1, 1'b0, "R4");
    step(1'b0, 1'b0, "R5");
    for (int c = 0; c < L - 1; c++) step(1'b1, 1'b0, "R5");
    chk("R5", tx_en_line, 1'b1, "line passes after restart");
    step(1'b1, 1'b0, "R3");
    chk("R3", jabber_active, 1'b1, "abort at limit after restart");
    // R4: long hold, saturation without wrap
    for (int c = 0; c < 4 * L; c++) step(1'b1, 1'b0, "R4");
    step(1'b0, 1'b0, "R5");
    // R7: status persists without a read
    for (int c = 0; c < 3; c++) step(1'b0, 1'b0, "R7");
    chk("R7", jabber_seen, 1'b1, "status held until read");
    step(1'b0, 1'b1, "R7");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule